// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block holds the modem control byte and the modem status byte of a serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator and carrier detect) pass through a two-stage synchroniser and are compared with the level seen one cycle earlier. Any change sets a sticky delta bit. A pending output is raised while any delta bit is set, so an interrupt controller can combine it with its other sources.

Software reaches the block through a single-byte register port. One select line picks the control byte or the status byte. A read of the status byte hands back its value and clears every delta bit in the same clock edge. A loopback bit in the control byte redirects status reads so they show the control outputs instead of the pins. Register access takes one cycle and is never stalled, so the port has no valid/ready handshake and no back-pressure. Read data is combinational and is valid in the cycle in which `rd_en` is high.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset, the control byte reads 0x08 (only aux output 2 set), the status byte reads 0xB0, and `msi_pending` is low.
- R2: A control write keeps bits [4:0] of `wr_data` (bit 0 DTR, bit 1 RTS, bit 2 aux output 1, bit 3 aux output 2, bit 4 loopback). These bits drive the five output pins from the next cycle, and bits [7:5] read as zero.
- R3: The status level bits are carrier detect in bit 7, ring in bit 6, data-set-ready in bit 5 and clear-to-send in bit 4. Each follows its pin on the third rising edge after the pin changes.
- R4: Delta bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are set on any change of their level and stay set until cleared.
- R5: Delta bit 2 is set only when the ring level falls from 1 to 0. A rising ring level leaves it unchanged.
- R6: A status read with loopback off returns the current byte, and all four delta bits are zero after that edge.
- R7: A delta event that lands on the same edge as a clearing status read is kept.
- R8: `msi_pending` is high exactly when any of the four delta bits is set.
- R9: With loopback on, a status read returns aux output 2 in bit 7, aux output 1 in bit 6, DTR in bit 5, RTS in bit 4 and zero in bits [3:0]. Such a read leaves the delta bits unchanged.
- R10: A write with the status byte selected changes nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a status read clears the deltas |
| rd_data | output | 8 | Read data, zero when `rd_en` is low |
| cts_i | input | 1 | Clear-to-send pin |
| dsr_i | input | 1 | Data-set-ready pin |
| ri_i | input | 1 | Ring indicator pin |
| dcd_i | input | 1 | Carrier detect pin |
| dtr_o | output | 1 | DTR output |
| rts_o | output | 1 | RTS output |
| out1_o | output | 1 | Aux output 1 |
| out2_o | output | 1 | Aux output 2 |
| loop_o | output | 1 | Loopback mode active |
| msi_pending | output | 1 | Any delta bit set |

## Verification
Two functions can fall on the same edge: a status read that clears the deltas, and a synchronised line change that sets one. The bench provokes this collision directly. It changes clear-to-send, waits two edges, and then reads on the third edge. It expects the read to show the old byte and a second read to show the new delta. Random stimulus then overlaps reads, pin changes and loopback toggles many more times. Every read is judged against a reference model, which clears the deltas first and then ORs in the new events.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int LINES   = 4;
  localparam int MCR_W   = 5;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // line vector order {dcd, ri, dsr, cts}
  localparam logic [LINES-1:0] LINE_RST = 4'b1011;
  localparam logic [MCR_W-1:0] MCR_RST  = 5'b01000;
  typedef enum logic { SEL_MCR = 1'b0, SEL_MSR = 1'b1 } sel_e;
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mst_delta.sv
module mst_delta #(
  parameter int LINES = 4,
  parameter int RI_IDX = 2,
  parameter logic [LINES-1:0] LVL_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] smp,
  input  logic             clr,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] dlt
);
  logic [LINES-1:0] evt;

  for (genvar i = 0; i < LINES; i++) begin : g_evt
    if (i == RI_IDX) begin : g_trail
      assign evt[i] = lvl[i] & ~smp[i];
    end else begin : g_any
      assign evt[i] = lvl[i] ^ smp[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= LVL_RST;
      dlt <= '0;
    end else begin
      lvl <= smp;
      dlt <= (dlt & ~{LINES{clr}}) | evt;
    end
  end

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((dlt & $past(dlt)) == $past(dlt))); // R4

  AST_RI_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dlt[RI_IDX] && !lvl[RI_IDX] && smp[RI_IDX]) |=> !dlt[RI_IDX]); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && smp == lvl) |=> (dlt == '0)); // R6

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && smp[0] != lvl[0]) |=> dlt[0]); // R7
endmodule

// File: rtl/mst_mcr.sv
module mst_mcr #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       loop_o,
  output logic       msi_pending
);
  logic [LINES-1:0] pins, smp, lvl, dlt;
  logic [MCR_W-1:0] mcr_q;
  logic             sel_msr, mcr_we, clr;
  logic [7:0]       msr_view;

  assign pins    = {dcd_i, ri_i, dsr_i, cts_i};
  assign sel_msr = (sel_e'(reg_sel) == SEL_MSR);
  assign mcr_we  = wr_en && !sel_msr;
  assign clr     = rd_en && sel_msr && !mcr_q[4];

  mst_sync #(.WIDTH(LINES), .STAGES(2), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(smp));

  mst_delta #(.LINES(LINES), .RI_IDX(IDX_RI), .LVL_RST(LINE_RST)) u_delta (
    .clk(clk), .rst_n(rst_n), .smp(smp), .clr(clr), .lvl(lvl), .dlt(dlt));

  mst_mcr #(.W(MCR_W), .RST_VAL(MCR_RST)) u_mcr (
    .clk(clk), .rst_n(rst_n), .we(mcr_we), .wd(wr_data[MCR_W-1:0]), .q(mcr_q));

  // loopback: aux2->carrier, aux1->ring, dtr->dsr, rts->cts
  always_comb begin
    if (mcr_q[4]) msr_view = {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], 4'b0000};
    else          msr_view = {lvl, dlt};
  end

  always_comb begin
    if (!rd_en)       rd_data = 8'h00;
    else if (sel_msr) rd_data = msr_view;
    else              rd_data = {3'b000, mcr_q};
  end

  assign dtr_o       = mcr_q[0];
  assign rts_o       = mcr_q[1];
  assign out1_o      = mcr_q[2];
  assign out2_o      = mcr_q[3];
  assign loop_o      = mcr_q[4];
  assign msi_pending = |dlt;

  AST_MCR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> ({3'b000, loop_o, out2_o, out1_o, rts_o, dtr_o} == ($past(wr_data) & 8'h1F))); // R2

  AST_PENDING_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && !loop_o) |-> (msi_pending == (|rd_data[3:0]))); // R8

  AST_LOOP_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && loop_o && msi_pending) |=> msi_pending); // R9
endmodule

// File: tb/sim_modem_status_tracker.sv
module sim_modem_status_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] pins = 4'b1011; // {dcd, ri, dsr, cts}
  logic dtr_o, rts_o, out1_o, out2_o, loop_o, msi_pending;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_status_tracker u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .cts_i(pins[0]), .dsr_i(pins[1]), .ri_i(pins[2]), .dcd_i(pins[3]),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .msi_pending(msi_pending));

  // reference model built from the requirements
  logic [3:0] m_s1, m_s2, m_lvl, m_dlt;
  logic [4:0] m_mcr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 4'b1011; m_s2 <= 4'b1011; m_lvl <= 4'b1011; m_dlt <= 4'b0; m_mcr <= 5'b01000;
    end else begin
      logic [3:0] ev;
      ev = m_lvl ^ m_s2;
      ev[2] = m_lvl[2] & ~m_s2[2];
      m_s1 <= pins; m_s2 <= m_s1; m_lvl <= m_s2;
      m_dlt <= ((rd_en && reg_sel && !m_mcr[4]) ? 4'b0 : m_dlt) | ev;
      if (wr_en && !reg_sel) m_mcr <= wr_data[4:0];
    end
  end

  function automatic logic [7:0] exp_read();
    if (!rd_en) return 8'h00;
    if (!reg_sel) return {3'b000, m_mcr};
    if (m_mcr[4]) return {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'b0000};
    return {m_lvl, m_dlt};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, settle, caller samples, then the edge acts
  task automatic step(input logic w, input logic r, input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; reg_sel = s; wr_data = d;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    step(0, 1, 0, 0); check("R1 mcr", rd_data, 8'h08);
    step(0, 1, 1, 0); check("R1 msr", rd_data, 8'hB0);
    check("R1 pending", {7'b0, msi_pending}, 8'h00);

    // R2 write masks upper bits, drives pins
    step(1, 0, 0, 8'hE7);
    step(0, 1, 0, 0); check("R2 mcr", rd_data, 8'h07);
    check("R2 pins", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h07);
    step(1, 0, 0, 8'h00);

    // R3/R4 cts falls: not visible after two edges, visible after three
    @(negedge clk); pins = 4'b1010;
    idle(2); check("R3 latency", {7'b0, msi_pending}, 8'h00);
    step(0, 1, 1, 0); check("R4 cts delta", rd_data, 8'hA1);
    check("R8 pending set", {7'b0, msi_pending}, 8'h01);
    step(0, 1, 1, 0); check("R6 cleared", rd_data, 8'hA0);
    check("R8 pending clear", {7'b0, msi_pending}, 8'h00);

    // R5 ring rise gives no delta, ring fall does
    @(negedge clk); pins = 4'b1110;
    idle(3); step(0, 1, 1, 0); check("R5 rise", rd_data, 8'hE0);
    @(negedge clk); pins = 4'b1010;
    idle(3); step(0, 1, 1, 0); check("R5 fall", rd_data, 8'hA4);

    // R7 read on the same edge as a cts event
    @(negedge clk); pins = 4'b1011;
    step(0, 0, 0, 0);
    step(0, 1, 1, 0); check("R7 old view", rd_data, 8'hA0);
    step(0, 1, 1, 0); check("R7 kept", rd_data, 8'hB1);

    // R9 loopback mapping, deltas preserved
    step(1, 0, 0, 8'h16);
    @(negedge clk); pins = 4'b1001;
    idle(3);
    step(0, 1, 1, 0); check("R9 map a", rd_data, 8'h50);
    step(1, 0, 0, 8'h19);
    step(0, 1, 1, 0); check("R9 map b", rd_data, 8'hA0);
    check("R9 keep pending", {7'b0, msi_pending}, 8'h01);
    step(1, 0, 0, 8'h00);
    step(0, 1, 1, 0); check("R9 delta after loop", rd_data, 8'h92);

    // R10 write to status select has no effect
    step(1, 0, 1, 8'hFF);
    step(0, 1, 1, 0); check("R10 msr", rd_data, 8'h90);
    step(0, 1, 0, 0); check("R10 mcr", rd_data, 8'h00);

    // random traffic against the model (R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pins = 4'($urandom);
      wr_en   = ($urandom_range(0, 15) == 0);
      rd_en   = ($urandom_range(0, 2) == 0);
      reg_sel = ($urandom_range(0, 3) != 0);
      wr_data = 8'($urandom) & ($urandom_range(0, 3) == 0 ? 8'hFF : 8'hEF);
      #1;
      check("R6 random read", rd_data, exp_read());
      check("R8 random pending", {7'b0, msi_pending}, {7'b0, |m_dlt});
    end
    idle(1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule